// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Switchable Oversampling

This block is a byte-wide asynchronous serial port behind a small register bus. Each register occupies one 32-bit word slot. Software programs a 16-bit baud divisor. It then writes bytes to be sent and reads bytes that have arrived. A status register tells it when it may write, when the line has drained and when data is waiting. Two modem-control bits drive DTR and RTS directly.

A speed-select register chooses how many baud ticks make up one bit. The default is sixteen ticks per bit. The alternative is four ticks per bit, which gives a bit rate four times higher from the same reference clock and divisor. Transmit and receive each have a 16-byte FIFO. Framing is fixed at one start bit, eight data bits sent LSB first, no parity and one stop bit.

Top module: `uart_os_port`

## Requirements
- R1: The byte address `addr` selects a word offset with bits 5:2. Any access with `addr[1:0]` not equal to 0 is ignored. Offset 7 is a scratch byte that reads back the last value written to it. Offset 3 reads back the line-control byte and offset 9 reads back the speed-select byte.
- R2: While bit 7 of the line-control byte (offset 3) is 1, offsets 0 and 1 read and write the low and high divisor bytes. While that bit is 0, offset 0 is transmit data on write and receive data on read, and offset 1 reads back the stored interrupt-enable byte.
- R3: One bit lasts D × K clock cycles, where D is the divisor (a divisor of 0 acts as 1). K is 16 when bit 1 of the speed-select byte is 0, and 4 when that bit is 1; so value 0 gives 16 and value 2 gives 4.
- R4: `txd` idles high. A frame is a low start bit, then eight data bits LSB first, then a high stop bit. Bytes leave in the order they were written.
- R5: The receiver assembles 8N1 frames into the receive FIFO. Status (offset 5) bit 0 is 1 while that FIFO is not empty. A read of offset 0 (divisor access off) returns the oldest byte and removes it.
- R6: Status bit 5 is 1 while the 16-entry transmit FIFO is not full, and a data write while it is full is dropped. Status bit 6 is 1 only when the transmit FIFO and the transmit shifter are both empty. After reset the status byte reads 0x60.
- R7: A write to offset 2 stores bit 0 as FIFO enable, which reads back as bits 7:6 of offset 2 (value 0xC1 when enabled, 0x01 otherwise). Bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Both clears act once and leave the FIFOs working afterwards.
- R8: Bit 0 of the modem-control byte (offset 4) drives `dtr` and bit 1 drives `rts`, active high. Both are 0 after reset.
- R9: A low level on `rxd` that is high again when the receiver re-checks it at mid start bit (tick 8 of 16, or tick 2 of 4) is discarded and stores no byte.
- R10: A frame that completes while the receive FIFO holds 16 bytes is lost. It sets status bit 1, which stays set until the status register is read. The 16 stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Byte address, word offset in bits 5:2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data, clears overrun) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| dtr | output | 1 | Data-terminal-ready output |
| rts | output | 1 | Request-to-send output |

## Verification
The assertions rely on several assumptions about the inputs. `rxd` is treated as an asynchronous level and passes through a two-flop synchronizer. A read or write strobe lasts a single cycle per access, and no access changes the divisor while a frame is on the line. The bench meets these assumptions. It changes the divisor and speed select only after the transmit side reports empty and the last byte has been received. It pulses every strobe for exactly one clock. It drives `rxd` either from `txd` in loopback or from whole-bit bit-banged levels and one short glitch.

// File: rtl/uart_os_port.sv
module uart_os_port #(
  parameter int FIFO_AW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       dtr,
  output logic       rts
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam logic [FIFO_AW:0] FULLV = (FIFO_AW+1)'(DEPTH);

  logic [7:0] dll, dlm, ier, lcr, mcr, scr, hs;
  logic       fifo_en, ovr;
  wire  [3:0] ofs  = addr[5:2];
  wire        sel  = (addr[1:0] == 2'b00);
  wire        dlab = lcr[7];
  wire        wr   = wr_en && sel;
  wire        rd   = rd_en && sel;
  wire        wr_thr = wr && ofs == 4'd0 && !dlab;
  wire        rd_rbr = rd && ofs == 4'd0 && !dlab;
  wire        rd_lsr = rd && ofs == 4'd5;
  wire        clr_rx = wr && ofs == 4'd2 && wdata[1];
  wire        clr_tx = wr && ofs == 4'd2 && wdata[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dll <= 8'd1; dlm <= '0; ier <= '0; lcr <= 8'h03;
      mcr <= '0; scr <= '0; hs <= '0; fifo_en <= 1'b0;
    end else if (wr) begin
      case (ofs)
        4'd0: if (dlab) dll <= wdata;
        4'd1: if (dlab) dlm <= wdata; else ier <= wdata;
        4'd2: fifo_en <= wdata[0];
        4'd3: lcr <= wdata;
        4'd4: mcr <= wdata;
        4'd7: scr <= wdata;
        4'd9: hs  <= wdata;
        default: ;
      endcase
    end

  assign dtr = mcr[0];
  assign rts = mcr[1];

  // baud tick
  wire  [15:0] div   = {dlm, dll};
  wire  [15:0] divm1 = (div == 16'd0) ? 16'd0 : div - 16'd1;
  logic [15:0] bcnt;
  wire         tick = (bcnt >= divm1);
  wire  [3:0]  osr_last  = hs[1] ? 4'd3 : 4'd15;
  wire  [3:0]  half_last = hs[1] ? 4'd1 : 4'd7;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? 16'd0 : bcnt + 16'd1;

  // transmit FIFO and shifter
  logic [7:0]       tx_mem [DEPTH];
  logic [FIFO_AW:0] tx_wp, tx_rp;
  wire  [FIFO_AW:0] tx_cnt  = tx_wp - tx_rp;
  wire              tx_full = (tx_cnt == FULLV);
  logic             tx_busy;
  logic [9:0]       tx_sh;
  logic [3:0]       tx_sub, tx_bit;
  wire              tx_push = wr_thr && !tx_full;
  wire              tx_pop  = tick && !tx_busy && tx_cnt != '0;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[FIFO_AW-1:0]] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0;
    end else begin
      if (clr_tx)      tx_rp <= tx_wp;
      else if (tx_pop) tx_rp <= tx_rp + 1'b1;
      if (tx_push)     tx_wp <= tx_wp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_sub <= '0; tx_bit <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1; tx_sh <= {1'b1, tx_mem[tx_rp[FIFO_AW-1:0]], 1'b0};
      tx_sub <= '0; tx_bit <= '0;
    end else if (tick && tx_busy) begin
      if (tx_sub == osr_last) begin
        tx_sub <= '0;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
        else                tx_bit  <= tx_bit + 4'd1;
      end else tx_sub <= tx_sub + 4'd1;
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receive synchronizer and shifter
  logic [2:0] rs;
  wire        rx_in = rs[1];
  wire        fall  = rs[2] && !rs[1];
  logic       rx_busy;
  logic [3:0] rx_sub, rx_bit;
  logic [7:0] rx_sh;
  wire        rx_done = rx_busy && tick && rx_bit == 4'd9 && rx_sub == osr_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= '1;
    else        rs <= {rs[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_sub <= '0; rx_bit <= '0; rx_sh <= '0;
    end else if (!rx_busy) begin
      if (fall) begin
        rx_busy <= 1'b1; rx_sub <= '0; rx_bit <= '0;
      end
    end else if (tick) begin
      if (rx_bit == 4'd0) begin
        if (rx_sub == half_last) begin
          if (rx_in) rx_busy <= 1'b0;
          else begin rx_sub <= '0; rx_bit <= 4'd1; end
        end else rx_sub <= rx_sub + 4'd1;
      end else if (rx_sub == osr_last) begin
        rx_sub <= '0;
        if (rx_bit == 4'd9) rx_busy <= 1'b0;
        else begin
          rx_sh  <= {rx_in, rx_sh[7:1]};
          rx_bit <= rx_bit + 4'd1;
        end
      end else rx_sub <= rx_sub + 4'd1;
    end

  // receive FIFO
  logic [7:0]       rx_mem [DEPTH];
  logic [FIFO_AW:0] rx_wp, rx_rp;
  wire  [FIFO_AW:0] rx_cnt  = rx_wp - rx_rp;
  wire              rx_full = (rx_cnt == FULLV);
  wire              rx_push = rx_done && !rx_full;
  wire              rx_pop  = rd_rbr && rx_cnt != '0;

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp[FIFO_AW-1:0]] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; ovr <= 1'b0;
    end else begin
      if (clr_rx)      rx_rp <= rx_wp;
      else if (rx_pop) rx_rp <= rx_rp + 1'b1;
      if (rx_push)     rx_wp <= rx_wp + 1'b1;
      if (rx_done && rx_full) ovr <= 1'b1;
      else if (rd_lsr)        ovr <= 1'b0;
    end

  wire [7:0] lsr = {1'b0, !tx_busy && tx_cnt == '0, !tx_full, 3'b000, ovr, rx_cnt != '0};

  always_comb
    case (ofs)
      4'd0: rdata = dlab ? dll : rx_mem[rx_rp[FIFO_AW-1:0]];
      4'd1: rdata = dlab ? dlm : ier;
      4'd2: rdata = {fifo_en, fifo_en, 6'b000001};
      4'd3: rdata = lcr;
      4'd4: rdata = mcr;
      4'd5: rdata = lsr;
      4'd7: rdata = scr;
      4'd9: rdata = hs;
      default: rdata = 8'h00;
    endcase

  // R4
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> txd);
  // R6
  temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n) lsr[6] |-> lsr[5]);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULLV && rx_cnt <= FULLV);
  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_rx && !rx_push |=> rx_cnt == '0);
  // R9
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy && tick && rx_bit == 4'd0 && rx_sub == half_last && rx_in |=> !rx_busy);
  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr) |-> $past(rx_done && rx_full));
endmodule

// File: tb/uart_os_port_tb_top.sv
module uart_os_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic txd, dtr, rts;
  logic loop = 1'b1, rx_drv = 1'b1;
  wire  rxd = loop ? txd : rx_drv;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  uart_os_port dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .dtr(dtr), .rts(rts));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); addr = {o, 2'b00}; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] o, output logic [7:0] v);
    @(negedge clk); addr = {o, 2'b00}; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_dr(output bit got);
    logic [7:0] v;
    got = 1'b0;
    for (int i = 0; i < 6000 && !got; i++) begin
      rd(4'd5, v);
      got = v[0];
    end
  endtask

  task automatic wait_temt();
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 20000 && !v[6]; i++) rd(4'd5, v);
  endtask

  task automatic cfg(input int d, input int h);
    wr(4'd3, 8'h83); wr(4'd0, 8'(d)); wr(4'd1, 8'(d >> 8)); wr(4'd3, 8'h03); wr(4'd9, 8'(h));
  endtask

  task automatic bb(input logic [7:0] b, input int per);
    @(negedge clk); rx_drv = 1'b0; repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; repeat (per) @(negedge clk); end
    rx_drv = 1'b1; repeat (per) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 R8 reset state
    rd(4'd5, v); chk(v == 8'h60, "R6 reset status", v, 8'h60);
    chk(txd && !dtr && !rts, "R8 reset pins", {txd, dtr, rts}, 3'b100);
    // R8
    wr(4'd4, 8'h01); chk(dtr && !rts, "R8 dtr only", {dtr, rts}, 2'b10);
    wr(4'd4, 8'h02); chk(!dtr && rts, "R8 rts only", {dtr, rts}, 2'b01);
    // R1 scratch and misaligned access
    wr(4'd7, 8'hA5); rd(4'd7, v); chk(v == 8'hA5, "R1 scratch", v, 8'hA5);
    @(negedge clk); addr = 6'b011101; wdata = 8'h3C; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    rd(4'd7, v); chk(v == 8'hA5, "R1 misaligned ignored", v, 8'hA5);
    // R2 divisor access vs interrupt enable
    wr(4'd1, 8'h0B);
    wr(4'd3, 8'h83); wr(4'd0, 8'h34); wr(4'd1, 8'h12);
    rd(4'd0, v); chk(v == 8'h34, "R2 divisor low", v, 8'h34);
    rd(4'd1, v); chk(v == 8'h12, "R2 divisor high", v, 8'h12);
    wr(4'd3, 8'h03);
    rd(4'd1, v); chk(v == 8'h0B, "R2 ier view", v, 8'h0B);
    rd(4'd3, v); chk(v == 8'h03, "R1 lcr readback", v, 8'h03);
    // R7 fifo enable view
    wr(4'd2, 8'h01); rd(4'd2, v); chk(v == 8'hC1, "R7 fifo enable", v, 8'hC1);
    // R3 R4 R5 sweep over divisor and speed select
    for (int d = 0; d < 4; d++)
      for (int h = 0; h <= 2; h += 2) begin
        int exp_w, w;
        logic [7:0] pat [3];
        pat[0] = 8'h55; pat[1] = 8'hA3 ^ 8'(d); pat[2] = 8'h0F + 8'(h);
        cfg(d, h);
        rd(4'd9, v); chk(v == 8'(h), "R1 speed readback", v, h);
        exp_w = (d == 0 ? 1 : d) * (h == 2 ? 4 : 16);
        wr(4'd0, pat[0]);
        @(negedge txd);
        w = 0;
        do begin @(posedge clk); #1 w++; end while (txd == 1'b0 && w < 5000);
        chk(w == exp_w, "R3 bit period", w, exp_w);
        wait_dr(got);
        rd(4'd0, v); chk(got && v == pat[0], "R4 R5 loopback 55", v, pat[0]);
        wr(4'd0, pat[1]); wr(4'd0, pat[2]);
        wait_temt();
        wait_dr(got); rd(4'd0, v); chk(got && v == pat[1], "R5 order first", v, pat[1]);
        wait_dr(got); rd(4'd0, v); chk(got && v == pat[2], "R5 order second", v, pat[2]);
        rd(4'd5, v); chk(v == 8'h60, "R5 R6 drained status", v, 8'h60);
      end
    // R10 overrun
    cfg(1, 2);
    for (int i = 0; i < 17; i++) wr(4'd0, 8'(i));
    repeat (1500) @(negedge clk);
    rd(4'd5, v); chk(v[1:0] == 2'b11, "R10 overrun set", v[1:0], 2'b11);
    rd(4'd5, v); chk(v[1] == 1'b0, "R10 overrun cleared", v[1], 0);
    for (int i = 0; i < 16; i++) begin
      rd(4'd0, v); chk(v == 8'(i), "R10 R5 kept bytes", v, i);
    end
    rd(4'd5, v); chk(v[0] == 1'b0, "R5 empty after pops", v[0], 0);
    // R6 full and drop
    cfg(8, 0);
    wr(4'd0, 8'hE0); repeat (20) @(negedge clk);
    for (int i = 1; i <= 20; i++) wr(4'd0, 8'(i));
    rd(4'd5, v); chk(v[6:5] == 2'b00, "R6 full no thre", v[6:5], 0);
    wait_dr(got); rd(4'd0, v); chk(got && v == 8'hE0, "R6 first byte", v, 8'hE0);
    for (int i = 1; i <= 16; i++) begin
      wait_dr(got); rd(4'd0, v); chk(got && v == 8'(i), "R6 kept byte", v, i);
    end
    wait_temt(); repeat (300) @(negedge clk);
    rd(4'd5, v); chk(v[0] == 1'b0, "R6 drops discarded", v[0], 0);
    // R7 transmit clear
    wr(4'd0, 8'hE1); repeat (20) @(negedge clk);
    for (int i = 0; i < 5; i++) wr(4'd0, 8'h70 + 8'(i));
    wr(4'd2, 8'h05);
    rd(4'd5, v); chk(v[5] == 1'b1, "R7 tx cleared thre", v[5], 1);
    wait_temt(); repeat (300) @(negedge clk);
    rd(4'd0, v); chk(v == 8'hE1, "R7 only shifter byte", v, 8'hE1);
    rd(4'd5, v); chk(v[0] == 1'b0, "R7 nothing else sent", v[0], 0);
    // R7 receive clear
    cfg(1, 2);
    wr(4'd0, 8'h11); wr(4'd0, 8'h22); wait_temt(); repeat (50) @(negedge clk);
    rd(4'd5, v); chk(v[0] == 1'b1, "R7 rx has data", v[0], 1);
    wr(4'd2, 8'h03);
    rd(4'd5, v); chk(v[0] == 1'b0, "R7 rx cleared", v[0], 0);
    wr(4'd0, 8'h33); wait_dr(got); rd(4'd0, v);
    chk(got && v == 8'h33, "R7 rx works after clear", v, 8'h33);
    // R9 glitch rejection then bit-banged frames
    loop = 1'b0;
    cfg(4, 0);
    @(negedge clk); rx_drv = 1'b0; repeat (10) @(negedge clk); rx_drv = 1'b1;
    repeat (800) @(negedge clk);
    rd(4'd5, v); chk(v[0] == 1'b0, "R9 glitch ignored 16x", v[0], 0);
    bb(8'h3C, 64); repeat (100) @(negedge clk);
    rd(4'd0, v); chk(v == 8'h3C, "R9 R5 real frame 16x", v, 8'h3C);
    cfg(4, 2);
    @(negedge clk); rx_drv = 1'b0; repeat (3) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(4'd5, v); chk(v[0] == 1'b0, "R9 glitch ignored 4x", v[0], 0);
    bb(8'hC5, 16); repeat (50) @(negedge clk);
    rd(4'd0, v); chk(v == 8'hC5, "R9 R5 real frame 4x", v, 8'hC5);
    finish_run();
  end
endmodule